// File: doc/BRIEF.md
# Low-Power Special Cycle Forwarder

This block watches the host cycles that the host bus decoder hands it. When a host special cycle asks the system to halt or to grant a stop, it puts the external cache SRAMs into stand-by by driving their chip selects inactive. It then asks the PCI side to run a special cycle of the same kind. When the PCI side acknowledges that cycle, the block gives the host its ready.

A configuration input decides whether the SRAMs are deselected at all. When stand-by is disabled, the selects stay active, but the special cycle is still forwarded with the same timing. The selects stay inactive through the ready and through any later special cycles. They become active again on the next ordinary, non-special host cycle.

There is a programmable gap between deselecting the SRAMs and raising the PCI request. This guarantees that the stand-by state is in place before the bus cycle starts. The PCI bus protocol itself lies outside this block: the block only issues a level request with a cycle type and waits for a one-cycle acknowledge.

Top module: `lpsc_forwarder`

## Requirements
- R1: A host cycle with `host_cyc_valid` and `host_cyc_special` both high is a low-power request when `host_sc_code` equals `HALT_CODE` (default 3'd1) or `STPG_CODE` (default 3'd2). A special cycle with any other code produces no request, no ready and no change to the selects.
- R2: If `stby_en` is 1 when a low-power request is sampled, every bit of `sram_cs_n` is 1 (deselected) from the clock edge that samples the request onward.
- R3: `pci_sc_req` rises exactly `GAP_CYCLES` clock edges after the edge that samples the request. In stand-by it is never high while any SRAM select is active.
- R4: `pci_sc_type` is 0 for a forwarded halt and 1 for a forwarded stop-grant.
- R5: `pci_sc_req` and `pci_sc_type` hold steady until `pci_sc_ack` is sampled high. The request is low after that edge.
- R6: `host_rdy` is high for exactly one cycle, following the edge at which `pci_sc_ack` is sampled with the request high.
- R7: If `stby_en` is 0 when a request is sampled, `sram_cs_n` keeps its value, and the cycle is still forwarded with the timing of R3.
- R8: While idle, a valid non-special host cycle drives all of `sram_cs_n` to 0 at the next edge. Deselected SRAMs stay deselected through the ready and through special cycles that are not low-power.
- R9: From the detection of a request until the ready, further host cycles are ignored: they neither restore the selects nor start a second request.
- R10: While reset is active, `sram_cs_n` is all 0, and `pci_sc_req` and `host_rdy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_cyc_valid | input | 1 | One-cycle strobe marking a decoded host cycle |
| host_cyc_special | input | 1 | The strobed cycle is a special cycle |
| host_sc_code | input | CODE_W | Special cycle code of the strobed cycle |
| stby_en | input | 1 | Enables SRAM stand-by on low-power cycles |
| sram_cs_n | output | NUM_BANKS | Active-low chip selects of the cache SRAM banks |
| pci_sc_req | output | 1 | Request for a special cycle on PCI |
| pci_sc_type | output | 1 | 0 = halt, 1 = stop-grant |
| pci_sc_ack | input | 1 | PCI side has run the requested cycle |
| host_rdy | output | 1 | One-cycle ready returned to the host |

## Verification
The bench builds the block with `GAP_CYCLES` = 3 and `NUM_BANKS` = 4. The longer gap lets it observe, on several consecutive cycles, that the request stays low while the selects are already inactive. The four banks show that every select moves together. The default codes are kept, so the bench can also drive a special cycle that is not low-power (code 0) and check that it is ignored. The bench holds back the acknowledge for several cycles to check that the request and type stay steady, and it injects host cycles in the middle of a sequence.

// File: rtl/lpsc_pkg.sv
package lpsc_pkg;

  typedef enum logic {
    SC_HALT  = 1'b0,
    SC_STPGNT = 1'b1
  } sc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic     lp_hit;
    sc_kind_e kind;
    logic     mem_hit;
  } host_class_t;

endpackage

// File: rtl/lpsc_rst_sync.sv
module lpsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lpsc_decode.sv
module lpsc_decode
  import lpsc_pkg::*;
#(
  parameter int          CODE_W    = 3,
  parameter logic [CODE_W-1:0] HALT_CODE = 3'd1,
  parameter logic [CODE_W-1:0] STPG_CODE = 3'd2
) (
  input  logic              cyc_valid,
  input  logic              cyc_special,
  input  logic [CODE_W-1:0] sc_code,
  output host_class_t       cls
);

  logic is_halt;
  logic is_stpg;

  always_comb begin
    is_halt     = (sc_code == HALT_CODE);
    is_stpg     = (sc_code == STPG_CODE);
    cls.lp_hit  = cyc_valid && cyc_special && (is_halt || is_stpg);
    cls.kind    = is_stpg ? SC_STPGNT : SC_HALT;
    cls.mem_hit = cyc_valid && !cyc_special;
  end

endmodule

// File: rtl/lpsc_seq.sv
module lpsc_seq
  import lpsc_pkg::*;
#(
  parameter int GAP_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  host_class_t cls,
  input  logic        stby_en,
  input  logic        ack,
  output logic        desel_set,
  output logic        restore,
  output logic        req,
  output sc_kind_e    req_kind,
  output logic        rdy,
  output logic        stby_cap
);

  localparam int CNT_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(GAP_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  sc_kind_e         kind_q;
  logic             stby_q;
  logic             rdy_q, rdy_d;
  logic             cap_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rdy_d   = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cls.lp_hit) begin
          cap_en  = 1'b1;
          state_d = ST_WAIT;
          cnt_d   = CNT_LOAD;
        end
      end
      ST_WAIT: begin
        if (cnt_q == '0) begin
          state_d = ST_REQ;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_REQ: begin
        if (ack) begin
          state_d = ST_IDLE;
          rdy_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rdy_q   <= rdy_d;
    end
  end

  // captured cycle attributes, enabled on detection only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= SC_HALT;
      stby_q <= 1'b0;
    end else if (cap_en) begin
      kind_q <= cls.kind;
      stby_q <= stby_en;
    end
  end

  assign desel_set = cap_en && stby_en;
  assign restore   = (state_q == ST_IDLE) && cls.mem_hit;
  assign req       = (state_q == ST_REQ);
  assign req_kind  = kind_q;
  assign rdy       = rdy_q;
  assign stby_cap  = stby_q;

  // R5: request and type steady until acknowledged
  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(req_kind)));

  // R5: request withdrawn after acknowledge
  a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack) |=> !req);

  // R6: ready is a single-cycle pulse
  a_r6_rdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);

  // R6: ready only follows an acknowledged request
  a_r6_rdy_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(req && ack));

endmodule

// File: rtl/lpsc_cs_ctrl.sv
module lpsc_cs_ctrl #(
  parameter int NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 desel_set,
  input  logic                 restore,
  output logic [NUM_BANKS-1:0] cs_n
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic cs_n_q, cs_n_d, cs_en;

    always_comb begin
      cs_en  = desel_set || restore;
      cs_n_d = desel_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cs_n_q <= 1'b0;
      end else if (cs_en) begin
        cs_n_q <= cs_n_d;
      end
    end

    assign cs_n[b] = cs_n_q;
  end

  // R2: deselect command reaches every bank
  a_r2_all_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    desel_set |=> (&cs_n));

  // R8: restore reselects every bank
  a_r8_all_selected: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (cs_n == '0));

  // R8: selects only move on a command
  a_r8_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!desel_set && !restore) |=> $stable(cs_n));

endmodule

// File: rtl/lpsc_forwarder.sv
module lpsc_forwarder
  import lpsc_pkg::*;
#(
  parameter int                CODE_W     = 3,
  parameter logic [CODE_W-1:0] HALT_CODE  = 3'd1,
  parameter logic [CODE_W-1:0] STPG_CODE  = 3'd2,
  parameter int                GAP_CYCLES = 2,
  parameter int                NUM_BANKS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_cyc_valid,
  input  logic                 host_cyc_special,
  input  logic [CODE_W-1:0]    host_sc_code,
  input  logic                 stby_en,
  output logic [NUM_BANKS-1:0] sram_cs_n,
  output logic                 pci_sc_req,
  output logic                 pci_sc_type,
  input  logic                 pci_sc_ack,
  output logic                 host_rdy
);

  logic        rst_sync_n;
  host_class_t cls;
  logic        desel_set;
  logic        restore;
  sc_kind_e    req_kind;
  logic        stby_cap;

  lpsc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lpsc_decode #(
    .CODE_W    (CODE_W),
    .HALT_CODE (HALT_CODE),
    .STPG_CODE (STPG_CODE)
  ) u_decode (
    .cyc_valid   (host_cyc_valid),
    .cyc_special (host_cyc_special),
    .sc_code     (host_sc_code),
    .cls         (cls)
  );

  lpsc_seq #(.GAP_CYCLES(GAP_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cls       (cls),
    .stby_en   (stby_en),
    .ack       (pci_sc_ack),
    .desel_set (desel_set),
    .restore   (restore),
    .req       (pci_sc_req),
    .req_kind  (req_kind),
    .rdy       (host_rdy),
    .stby_cap  (stby_cap)
  );

  lpsc_cs_ctrl #(.NUM_BANKS(NUM_BANKS)) u_cs_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .desel_set (desel_set),
    .restore   (restore),
    .cs_n      (sram_cs_n)
  );

  assign pci_sc_type = (req_kind == SC_STPGNT);

  // R3: stand-by is in place whenever the bus request is up
  a_r3_desel_before_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pci_sc_req && stby_cap) |-> (&sram_cs_n));

  // R9: no restore of the selects while a sequence is running
  a_r9_busy_no_restore: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pci_sc_req && stby_cap) |=> (pci_sc_req ? (&sram_cs_n) : 1'b1));

endmodule

// File: tb/lpsc_forwarder_bench.sv
module lpsc_forwarder_bench;

  localparam int CODE_W = 3;
  localparam int GAP    = 3;
  localparam int NB     = 4;
  localparam logic [2:0] C_HALT = 3'd1;
  localparam logic [2:0] C_STPG = 3'd2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_cyc_valid = 1'b0;
  logic          host_cyc_special = 1'b0;
  logic [2:0]    host_sc_code = '0;
  logic          stby_en = 1'b0;
  logic [NB-1:0] sram_cs_n;
  logic          pci_sc_req;
  logic          pci_sc_type;
  logic          pci_sc_ack = 1'b0;
  logic          host_rdy;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #10 clk = ~clk;

  lpsc_forwarder #(
    .CODE_W(CODE_W), .HALT_CODE(C_HALT), .STPG_CODE(C_STPG),
    .GAP_CYCLES(GAP), .NUM_BANKS(NB)
  ) u_lpsc_forwarder (
    .clk(clk), .rst_n(rst_n),
    .host_cyc_valid(host_cyc_valid), .host_cyc_special(host_cyc_special),
    .host_sc_code(host_sc_code), .stby_en(stby_en),
    .sram_cs_n(sram_cs_n), .pci_sc_req(pci_sc_req), .pci_sc_type(pci_sc_type),
    .pci_sc_ack(pci_sc_ack), .host_rdy(host_rdy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic drive_cycle(input logic special, input logic [2:0] code);
    @(negedge clk);
    host_cyc_valid = 1'b1; host_cyc_special = special; host_sc_code = code;
    @(negedge clk);
    host_cyc_valid = 1'b0; host_cyc_special = 1'b0; host_sc_code = '0;
  endtask

  // one full low-power sequence; returns at the negedge after the ready pulse
  task automatic fwd(input logic [2:0] code, input int exp_type,
                     input bit exp_cs_high, input int ack_wait);
    int exp_cs;
    exp_cs = exp_cs_high ? (1 << NB) - 1 : 0;
    drive_cycle(1'b1, code);
    check(sram_cs_n == NB'(exp_cs), exp_cs_high ? "R2" : "R7", sram_cs_n, exp_cs);
    for (int i = 0; i < GAP; i++) begin
      check(pci_sc_req == 1'b0, "R3 early", pci_sc_req, 0);
      @(negedge clk);
    end
    check(pci_sc_req == 1'b1, "R3 rise", pci_sc_req, 1);
    check(pci_sc_type == exp_type[0], "R4", pci_sc_type, exp_type);
    check(sram_cs_n == NB'(exp_cs), "R3 cs at req", sram_cs_n, exp_cs);
    for (int i = 0; i < ack_wait; i++) begin
      @(negedge clk);
      check(pci_sc_req == 1'b1 && pci_sc_type == exp_type[0], "R5 hold", pci_sc_req, 1);
      check(host_rdy == 1'b0, "R6 early", host_rdy, 0);
    end
    pci_sc_ack = 1'b1;
    @(negedge clk);
    pci_sc_ack = 1'b0;
    check(pci_sc_req == 1'b0, "R5 drop", pci_sc_req, 0);
    check(host_rdy == 1'b1, "R6 rise", host_rdy, 1);
    @(negedge clk);
    check(host_rdy == 1'b0, "R6 pulse", host_rdy, 0);
    check(sram_cs_n == NB'(exp_cs), "R8 after rdy", sram_cs_n, exp_cs);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(sram_cs_n == '0, "R10 cs", sram_cs_n, 0);
    check(pci_sc_req == 1'b0, "R10 req", pci_sc_req, 0);
    check(host_rdy == 1'b0, "R10 rdy", host_rdy, 0);
  endtask

  task automatic t_halt_stby();
    stby_en = 1'b1;
    fwd(C_HALT, 0, 1'b1, 4);
  endtask

  task automatic t_stpg_stby_hold();
    stby_en = 1'b1;
    fwd(C_STPG, 1, 1'b1, 2);
    drive_cycle(1'b1, 3'd0);
    check(sram_cs_n == '1, "R8 other special keeps cs", sram_cs_n, (1 << NB) - 1);
    check(pci_sc_req == 1'b0, "R1 other code", pci_sc_req, 0);
    drive_cycle(1'b0, 3'd0);
    check(sram_cs_n == '0, "R8 restore", sram_cs_n, 0);
  endtask

  task automatic t_ignored_code();
    drive_cycle(1'b1, 3'd5);
    for (int i = 0; i < GAP + 3; i++) begin
      check(pci_sc_req == 1'b0 && host_rdy == 1'b0, "R1 ignored", pci_sc_req, 0);
      check(sram_cs_n == '0, "R1 cs untouched", sram_cs_n, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_no_stby();
    stby_en = 1'b0;
    fwd(C_STPG, 1, 1'b0, 1);
    fwd(C_HALT, 0, 1'b0, 0);
    stby_en = 1'b1;
  endtask

  task automatic t_busy();
    stby_en = 1'b1;
    drive_cycle(1'b1, C_STPG);
    check(sram_cs_n == '1, "R2 busy start", sram_cs_n, (1 << NB) - 1);
    drive_cycle(1'b0, 3'd0);
    check(sram_cs_n == '1, "R9 mem ignored", sram_cs_n, (1 << NB) - 1);
    drive_cycle(1'b1, C_HALT);
    check(pci_sc_req == 1'b1 && pci_sc_type == 1'b1, "R9 type kept", pci_sc_type, 1);
    pci_sc_ack = 1'b1;
    @(negedge clk);
    pci_sc_ack = 1'b0;
    check(host_rdy == 1'b1, "R6 busy rdy", host_rdy, 1);
    for (int i = 0; i < GAP + 3; i++) begin
      @(negedge clk);
      check(pci_sc_req == 1'b0, "R9 no second req", pci_sc_req, 0);
    end
    drive_cycle(1'b0, 3'd0);
    check(sram_cs_n == '0, "R8 restore after busy", sram_cs_n, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_halt_stby();
    drive_cycle(1'b0, 3'd0);
    check(sram_cs_n == '0, "R8 restore first", sram_cs_n, 0);
    t_ignored_code();
    t_stpg_stby_hold();
    t_no_stby();
    t_busy();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule